// File: doc/BRIEF.md
# Tuner Synthesizer Configuration Slave on I2C

This block is a write-mostly I2C slave that holds the settings of a frequency-synthesizer tuner. It samples SCL and SDA with the system clock, finds START and STOP conditions, and drives an open-drain enable that pulls SDA low. The settings it keeps are a 15-bit programmable divider word, a seven-bit control field and three band-switch bits. The surrounding tuner logic reads these directly from the block's outputs.

A write transfer names the slave and then sends any number of data bytes before STOP. The top bit of each data byte selects its meaning. A clear top bit starts a two-byte divider update, and the divider changes only when the second byte of the pair arrives. A set top bit marks a control byte, and the byte after it is taken as the band byte. A read transfer returns one status byte that carries a power-on flag and the lock indication from the synthesizer. The two low address bits come from a hardware strap and arrive as digital levels.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1,1,0,0,0 followed by `hw_addr[1]`, `hw_addr[0]`. Bit 0 of the address byte selects read (1) or write (0). On any other address it gives no ACK and ignores every bus clock until the next START.
- R2: A write data byte with bit 7 = 0 supplies `div_word[14:8]` from its bits 6..0. The following byte supplies `div_word[7:0]`. `div_word` changes only when the second byte is acknowledged, and it stays unchanged while only the first byte has arrived.
- R3: A write data byte with bit 7 = 1 is a control byte and is committed on its own ACK. Bit 6 drives `cp_hi`, bits 5..3 drive `test_mode[2:0]`, bits 2..1 drive `ref_sel[1:0]` and bit 0 drives `tune_off`.
- R4: The byte after a control byte is a band byte. Its bits 2..0 drive `band[2:0]` on its ACK, and its bits 7..3 have no effect.
- R5: Data bytes may follow one address until STOP. After a completed divider pair or band byte, the next byte is routed again by its bit 7, so repeated divider pairs sweep `div_word`.
- R6: A START or STOP that arrives after only the first divider byte discards that byte. All previously committed settings stay unchanged.
- R7: After an acknowledged read address, the slave shifts out the status byte MSB first. Bit 7 is the power-on flag, bit 6 is `lock_i`, and bits 5..0 are all 1.
- R8: The power-on flag is 1 after reset and becomes 0 once a status byte has been fully shifted out. It never returns to 1 without a reset.
- R9: After reset the outputs are: `div_word` = 0, `cp_hi` = 0, `test_mode` = 000, `ref_sel` = 11 (coarsest step), `tune_off` = 1, `band` = 000.
- R10: SDA is pulled low during the ACK clock of every byte the slave accepts. SDA is released while the master drives. The open-drain enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| hw_addr | input | 2 | Strapped low address bits |
| lock_i | input | 1 | Synthesizer lock indication |
| div_word | output | 15 | Committed divider word |
| cp_hi | output | 1 | High charge-pump current select |
| test_mode | output | 3 | Test selection bits |
| ref_sel | output | 2 | Reference divider select |
| tune_off | output | 1 | Tuning amplifier disabled |
| band | output | 3 | Band-switch outputs |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a 15-bit divider and three band bits. These cover every bit of the divider's upper field (seven bits) and of the control field. The bench runs the bus at eighteen system clocks per bit, which leaves room for the synchronizer latency before each edge. Random transfers mix divider pairs, control and band pairs, strap values, mismatched addresses and status reads. Directed cases cover a pair cut off by STOP or by a repeated START, band bytes with junk in their upper bits, and the one-shot clearing of the power-on flag.

// File: rtl/tuner_i2c_pkg.sv
// Shared types and constants for the tuner configuration slave.
package tuner_i2c_pkg;

    // Bus-side protocol states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WACK,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } bus_state_t;

    // Routing state for incoming write data bytes.
    typedef enum logic [1:0] {
        SEQ_ANY,
        SEQ_DIV_LO,
        SEQ_BAND
    } seq_t;

    // Control field, MSB first as it arrives on the bus below the route bit.
    typedef struct packed {
        logic       cp;
        logic [2:0] test;
        logic [1:0] ref_sel;
        logic       tune_off;
    } ctrl_t;

    localparam ctrl_t     CTRL_RESET = '{cp: 1'b0, test: 3'b000, ref_sel: 2'b11, tune_off: 1'b1};
    localparam logic [4:0] ADDR_FIXED = 5'b11000;

endpackage

// File: rtl/tuner_i2c_sync.sv
// Bus line conditioner.
// Brings SCL and SDA into the clock domain through STAGES flops and flags
// SCL edges, START and STOP. Assumes the system clock samples every bus
// level at least three times.
module tuner_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains, idle-high reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // One-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/tuner_i2c_link.sv
// Byte-level protocol engine.
// Shifts bits on SCL rising edges, drives ACK and read data after SCL
// falling edges, matches the address and hands each accepted write byte
// on as a one-cycle strobe. Assumes conditioned inputs from tuner_i2c_sync.
module tuner_i2c_link
    import tuner_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [1:0] hw_addr,
    input  logic [7:0] status_byte,
    output logic       sda_oe,
    output logic       wr_valid,
    output logic [7:0] wr_byte,
    output logic       status_sent
);
    bus_state_t state;
    logic [7:0] shreg;
    logic [3:0] bitcnt;
    logic       rw;
    logic       addr_hit;

    // Address comparison against the fixed prefix and strap.
    assign addr_hit = (shreg[7:1] == {ADDR_FIXED, hw_addr});

    // Protocol sequencing, ACK and read data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            bitcnt      <= '0;
            rw          <= 1'b0;
            sda_oe      <= 1'b0;
            wr_valid    <= 1'b0;
            wr_byte     <= '0;
            status_sent <= 1'b0;
        end else begin
            wr_valid    <= 1'b0;
            status_sent <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    state  <= ST_WACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                sda_oe   <= 1'b1;
                                wr_valid <= 1'b1;
                                wr_byte  <= shreg;
                                state    <= ST_WACK;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                shreg  <= status_byte;
                                sda_oe <= ~status_byte[7];
                                bitcnt <= 4'd1;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe      <= 1'b0;
                                status_sent <= 1'b1;
                                state       <= ST_RACK;
                            end else begin
                                sda_oe <= ~shreg[6];
                                shreg  <= {shreg[6:0], 1'b1};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            state <= sda_s ? ST_SKIP : ST_WACK;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tuner_i2c_regfile.sv
// Setting registers and write-byte router.
// Routes each accepted write byte by its top bit, holds the upper divider
// half until its partner arrives, and keeps the power-on flag. Any START
// or STOP clears the routing state and drops a half-received pair.
module tuner_i2c_regfile
    import tuner_i2c_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int BAND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [7:0]        wr_byte,
    input  logic              xfer_edge,
    input  logic              status_sent,
    input  logic              lock_i,
    output logic [DIV_W-1:0]  div_q,
    output ctrl_t             ctrl_q,
    output logic [BAND_W-1:0] band_q,
    output logic              por_q,
    output logic [7:0]        status_byte
);
    localparam int HI_W = DIV_W - 8;

    seq_t            seq;
    logic [HI_W-1:0] div_hi;

    // Byte routing and commit of the settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq    <= SEQ_ANY;
            div_hi <= '0;
            div_q  <= '0;
            ctrl_q <= CTRL_RESET;
            band_q <= '0;
        end else if (xfer_edge) begin
            seq <= SEQ_ANY;
        end else if (wr_valid) begin
            case (seq)
                SEQ_DIV_LO: begin
                    div_q <= {div_hi, wr_byte};
                    seq   <= SEQ_ANY;
                end
                SEQ_BAND: begin
                    band_q <= wr_byte[BAND_W-1:0];
                    seq    <= SEQ_ANY;
                end
                default: begin
                    if (wr_byte[7]) begin
                        ctrl_q <= ctrl_t'(wr_byte[6:0]);
                        seq    <= SEQ_BAND;
                    end else begin
                        div_hi <= wr_byte[HI_W-1:0];
                        seq    <= SEQ_DIV_LO;
                    end
                end
            endcase
        end
    end

    // Power-on flag, cleared once a status byte leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q <= 1'b1;
        end else if (status_sent) begin
            por_q <= 1'b0;
        end
    end

    assign status_byte = {por_q, lock_i, 6'b111111};
endmodule

// File: rtl/tuner_i2c_regs.sv
// Top of the tuner configuration slave.
// Joins the line conditioner, the protocol engine and the setting
// registers. The caller provides an external pull-up and the open-drain
// pad, and presents the hardware address bits as steady levels.
module tuner_i2c_regs
    import tuner_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 15,
    parameter int BAND_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        hw_addr,
    input  logic              lock_i,
    output logic [DIV_W-1:0]  div_word,
    output logic              cp_hi,
    output logic [2:0]        test_mode,
    output logic [1:0]        ref_sel,
    output logic              tune_off,
    output logic [BAND_W-1:0] band
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_valid, status_sent, por_q;
    logic [7:0] wr_byte, status_byte;
    ctrl_t      ctrl_q;

    tuner_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tuner_i2c_link u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .hw_addr     (hw_addr),
        .status_byte (status_byte),
        .sda_oe      (sda_oe),
        .wr_valid    (wr_valid),
        .wr_byte     (wr_byte),
        .status_sent (status_sent)
    );

    tuner_i2c_regfile #(.DIV_W(DIV_W), .BAND_W(BAND_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_byte     (wr_byte),
        .xfer_edge   (start_det | stop_det),
        .status_sent (status_sent),
        .lock_i      (lock_i),
        .div_q       (div_word),
        .ctrl_q      (ctrl_q),
        .band_q      (band),
        .por_q       (por_q),
        .status_byte (status_byte)
    );

    // Spread the control field onto its output pins.
    always_comb begin
        cp_hi     = ctrl_q.cp;
        test_mode = ctrl_q.test;
        ref_sel   = ctrl_q.ref_sel;
        tune_off  = ctrl_q.tune_off;
    end

    logic unused_scl;
    assign unused_scl = scl_s;
endmodule

// File: rtl/tuner_i2c_regs_chk.sv
// Property checker for tuner_i2c_regs, attached by bind.
module tuner_i2c_regs_chk #(
    parameter int DIV_W  = 15,
    parameter int BAND_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [DIV_W-1:0]  div_word,
    input logic [6:0]        ctrl_bits,
    input logic [BAND_W-1:0] band,
    input logic              por_q
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (div_word == '0 && ctrl_bits == 7'b0000111 && band == '0 && por_q)); // R9

    AST_DIV_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (div_word != $past(div_word)) |-> sda_oe); // R2

    AST_CTRL_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits != $past(ctrl_bits)) |-> sda_oe); // R3

    AST_BAND_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (band != $past(band)) |-> sda_oe); // R4

    AST_POR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(por_q)); // R8

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i); // R10
endmodule

bind tuner_i2c_regs tuner_i2c_regs_chk #(.DIV_W(DIV_W), .BAND_W(BAND_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .div_word  (div_word),
    .ctrl_bits ({cp_hi, test_mode, ref_sel, tune_off}),
    .band      (band),
    .por_q     (por_q)
);

// File: tb/tuner_i2c_regs_test.sv
module tuner_i2c_regs_test;
    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  hw_pin = 2'b00;
    logic        lock = 1'b0;
    logic        sda_oe;
    logic        sda_bus;
    logic [14:0] div_word;
    logic        cp_hi, tune_off;
    logic [2:0]  test_mode, band;
    logic [1:0]  ref_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state computed from the requirements.
    logic [14:0] m_div;
    logic [6:0]  m_ctrl;
    logic [2:0]  m_band;
    logic        m_por;
    int          m_seq;
    logic [6:0]  m_hi;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    tuner_i2c_regs uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .hw_addr(hw_pin), .lock_i(lock), .div_word(div_word), .cp_hi(cp_hi),
        .test_mode(test_mode), .ref_sel(ref_sel), .tune_off(tune_off), .band(band)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        b = sda_bus;  tick(Q - Q / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(nack);
    endtask

    // Requirement-level model of one accepted write byte.
    task automatic m_apply(input logic [7:0] v);
        if (m_seq == 1) begin
            m_div = {m_hi, v}; m_seq = 0;
        end else if (m_seq == 2) begin
            m_band = v[2:0]; m_seq = 0;
        end else if (v[7]) begin
            m_ctrl = v[6:0]; m_seq = 2;
        end else begin
            m_hi = v[6:0]; m_seq = 1;
        end
    endtask

    task automatic chk_regs(input string tag);
        chk({tag, " div_word"}, 32'(div_word), 32'(m_div));
        chk({tag, " control"}, 32'({cp_hi, test_mode, ref_sel, tune_off}), 32'(m_ctrl));
        chk({tag, " band"}, 32'(band), 32'(m_band));
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] a, input logic r);
        return {5'b11000, a, r};
    endfunction

    // Write transfer: address strap a, n data bytes, ends with STOP.
    task automatic wr_txn(input string tag, input logic [1:0] a, input int n, input logic [7:0] d[8]);
        logic ack;
        bit   hit;
        hit = (a == hw_pin);
        bus_start();
        m_seq = 0;
        put_byte(addr_byte(a, 1'b0), ack);
        chk({tag, " R1 address ack"}, 32'(ack), hit ? 0 : 1);
        for (int i = 0; i < n; i++) begin
            put_byte(d[i], ack);
            chk({tag, " R10 data ack"}, 32'(ack), hit ? 0 : 1);
            if (hit) m_apply(d[i]);
        end
        bus_stop();
        m_seq = 0;
        chk_regs({tag, " R5"});
    endtask

    task automatic rd_txn(input string tag);
        logic       ack;
        logic [7:0] v;
        bus_start();
        put_byte(addr_byte(hw_pin, 1'b1), ack);
        chk({tag, " R7 read address ack"}, 32'(ack), 0);
        get_byte(v, 1'b1);
        chk({tag, " R7 R8 status byte"}, 32'(v), 32'({m_por, lock, 6'b111111}));
        m_por = 1'b0;
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R5 actual=timeout expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d[8];
        logic       ack;
        int         seed;
        seed = 2024;
        void'($urandom(seed));
        m_div = '0; m_ctrl = 7'b0000111; m_band = '0; m_por = 1'b1; m_seq = 0; m_hi = '0;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R9: reset state.
        chk_regs("R9 reset");
        chk("R9 sda released", 32'(sda_oe), 0);

        // R7/R8: status reads, flag clears after first byte.
        rd_txn("first read");
        lock = 1'b1;
        rd_txn("second read");

        // R2: divider pair, unchanged after first half.
        bus_start();
        put_byte(addr_byte(hw_pin, 1'b0), ack);
        put_byte(8'h12, ack);
        chk("R2 divider held after first half", 32'(div_word), 32'(m_div));
        put_byte(8'h34, ack);
        chk("R10 ack second half", 32'(ack), 0);
        bus_stop();
        m_div = {7'h12, 8'h34};
        chk("R2 divider pair committed", 32'(div_word), 32'(m_div));

        // R3/R4: control then band with junk upper bits.
        d[0] = 8'hD5; d[1] = 8'hFE;
        wr_txn("R3 R4 ctrl band", hw_pin, 2, d);
        chk("R3 test_mode field", 32'(test_mode), 3'b010);
        chk("R4 band low bits only", 32'(band), 3'b110);

        // R5: sweep of three pairs, then control mid-stream.
        d[0] = 8'h01; d[1] = 8'h10; d[2] = 8'h02; d[3] = 8'h20;
        d[4] = 8'h7F; d[5] = 8'hFF; d[6] = 8'h80; d[7] = 8'h05;
        wr_txn("R5 sweep", hw_pin, 8, d);
        chk("R5 final sweep value", 32'(div_word), 32'(15'h7FFF));

        // R6: pair cut by STOP.
        d[0] = 8'h55;
        wr_txn("R6 stop abort", hw_pin, 1, d);
        // R6: next transfer starts fresh; a single byte is again a first half.
        d[0] = 8'h07;
        wr_txn("R6 fresh route", hw_pin, 1, d);
        // R6: pair cut by repeated START.
        bus_start();
        put_byte(addr_byte(hw_pin, 1'b0), ack);
        put_byte(8'h3C, ack);
        bus_start();
        put_byte(addr_byte(hw_pin, 1'b0), ack);
        put_byte(8'hC0, ack);
        bus_stop();
        m_ctrl = 7'h40;
        chk_regs("R6 repeated start");

        // R1: wrong strap, nothing acknowledged or changed.
        hw_pin = 2'b10;
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h81;
        wr_txn("R1 mismatch", 2'b01, 3, d);
        wr_txn("R1 strap match", 2'b10, 2, d);

        // Random mix.
        for (int t = 0; t < 40; t++) begin
            int n;
            logic [1:0] a;
            if ($urandom % 6 == 0) begin
                lock = 1'($urandom);
                rd_txn("random read");
            end else begin
                n = 1 + ($urandom % 8);
                a = ($urandom % 5 == 0) ? 2'($urandom) : hw_pin;
                for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
                wr_txn("random write", a, n, d);
            end
            if (t % 10 == 9) hw_pin = 2'($urandom);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule